// File: doc/BRIEF.md
# Strided Two-Dimensional Transfer Address Engine

This block is the address and count engine of a single transfer channel. It turns a small set of parameters into one address per data element: a start address, a row length with a signed byte step, and, in two-dimensional operation, a row count with a signed step applied between rows. A downstream mover consumes the elements one at a time. The engine supplies the address, the transfer direction and the element width, and it reports the end of a row and the end of the whole work unit.

When a work unit ends, the engine acts on its flow setting. It can halt, start the same buffer again, or read the parameters of the next work unit as 16-bit halfwords from memory through a simple read port. A descriptor can come in one of three shapes: a large form with a full 32-bit link, a small form that updates only the low half of the link, or an array form whose entries sit back to back and carry no link at all.

Top module: `dma2d_walk_engine`

## Requirements
- R1: After reset, `elem_valid`, `rd_req`, `unit_done`, `row_done` and `irq` are low, and both current counts read zero.
- R2: When `enable` is seen high in the idle state, the current counts read zero for one cycle. The first element then appears one cycle later with `elem_addr` equal to the start address and the current row count equal to the row length.
- R3: In linear mode (config bit 4 = 0), each accepted element moves the address by the sign-extended 16-bit row step. `unit_done` pulses for one cycle after the element that uses up the row length. `elem_width` shows config bits 3:2 (0 = 8-bit, 1 = 16-bit, 2 = 32-bit) and `elem_write` shows config bit 1.
- R4: In two-dimensional mode (config bit 4 = 1), the last element of a row moves the address by the signed row-to-row step instead of the row step, reloads the row count and decrements the remaining-row count. `row_done` pulses once for each row, including the last one.
- R5: Config bits 7:6 select `irq`. A value of 0 gives no pulse. A value of 2 gives one pulse per work unit. A value of 3 gives one pulse per row in two-dimensional mode, and one pulse per work unit in linear mode.
- R6: With flow code 0 (config bits 15:12), no further element is produced after the work unit ends until `enable` goes low and then high again.
- R7: With flow code 1, the same buffer starts again from the start address with the original lengths after each work unit.
- R8: Flow codes 4, 6 and 7 fetch the next work unit's parameters before generating any element. Config bits 11:8 give the number of halfwords to fetch. Halfwords are read at rising addresses, 2 bytes apart, and one halfword is taken per cycle in which `rd_req` and `rd_gnt` are both high, with `rd_data` valid in that same cycle. The large form (code 7) holds, in order: link low, link high, start low, start high, config, row length, row step, row count, row-to-row step.
- R9: The small form (code 6) holds link low, start low, start high, config, row length, row step, row count and row-to-row step. Only the low 16 bits of the link are replaced, and the next fetch begins at the link.
- R10: The array form (code 4) holds start low, start high, config, row length, row step, row count and row-to-row step. The next fetch continues at the halfword just after the previous descriptor.
- R11: While `enable` is low, `elem_valid` and `rd_req` are low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel run level; a rise from idle starts the engine |
| cfg_in | input | 16 | Configuration word used at start |
| start_in | input | 32 | Start address used at start |
| link_in | input | 32 | Initial descriptor address |
| x_len_in | input | 16 | Elements per row |
| x_step_in | input | 16 | Signed byte step inside a row |
| y_len_in | input | 16 | Number of rows |
| y_step_in | input | 16 | Signed byte step applied at a row end |
| elem_take | input | 1 | Mover accepts the presented element |
| rd_gnt | input | 1 | Halfword read accepted, data valid |
| rd_data | input | 16 | Fetched halfword |
| rd_req | output | 1 | Halfword read request |
| rd_addr | output | 32 | Halfword read address |
| elem_valid | output | 1 | An element address is presented |
| elem_addr | output | 32 | Element byte address |
| elem_write | output | 1 | 1 = memory write, 0 = memory read |
| elem_width | output | 2 | Element width code |
| cur_x_left | output | 16 | Current count left in the row |
| cur_y_left | output | 16 | Current count of rows left |
| unit_done | output | 1 | One-cycle pulse at the end of a work unit |
| row_done | output | 1 | One-cycle pulse at each row end (2D) |
| irq | output | 1 | One-cycle interrupt pulse, as selected |

## Verification
The embedded properties assume that `rd_data` is valid in the cycle `rd_gnt` is high. They also assume that every fetching flow code comes with a non-zero halfword count, and that `enable` stays high for a whole work unit unless the run is meant to stop. The directed stimulus obeys these limits. It returns memory data combinationally from a bench array indexed by `rd_addr` and places every descriptor at a halfword-aligned address. It drops `enable` only between scenarios or on purpose in the abort case. Grants are stalled on alternate cycles in one chained scenario, so the fetch ordering is exercised under back-pressure.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    localparam int ADDR_W = 32;
    localparam int HALF_W = 16;
    localparam int IDX_W  = 4;

    localparam logic [3:0] FLOW_STOP  = 4'd0;
    localparam logic [3:0] FLOW_AUTO  = 4'd1;
    localparam logic [3:0] FLOW_ARRAY = 4'd4;
    localparam logic [3:0] FLOW_SMALL = 4'd6;
    localparam logic [3:0] FLOW_LARGE = 4'd7;

    localparam logic [1:0] IRQ_UNIT = 2'd2;
    localparam logic [1:0] IRQ_ROW  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN,
        ST_FETCH,
        ST_HALT
    } eng_state_e;

    // positions follow the large descriptor layout; other forms map onto it
    typedef enum logic [3:0] {
        FLD_LINK_LO,
        FLD_LINK_HI,
        FLD_START_LO,
        FLD_START_HI,
        FLD_CFG,
        FLD_XLEN,
        FLD_XSTEP,
        FLD_YLEN,
        FLD_YSTEP,
        FLD_NONE
    } desc_field_e;

    typedef struct packed {
        eng_state_e          st;
        logic [HALF_W-1:0]   cfg;
        logic [ADDR_W-1:0]   start;
        logic [ADDR_W-1:0]   link;
        logic [HALF_W-1:0]   xlen;
        logic [HALF_W-1:0]   xstep;
        logic [HALF_W-1:0]   ylen;
        logic [HALF_W-1:0]   ystep;
        logic [ADDR_W-1:0]   dptr;
        logic [IDX_W-1:0]    fidx;
        logic [IDX_W-1:0]    ftot;
        logic [3:0]          fflow;
        logic [ADDR_W-1:0]   addr;
        logic [HALF_W-1:0]   cx;
        logic [HALF_W-1:0]   cy;
        logic                unit_done;
        logic                row_done;
        logic                irq;
    } eng_regs_s;

    function automatic logic is_fetch_flow(input logic [3:0] f);
        return (f == FLOW_ARRAY) || (f == FLOW_SMALL) || (f == FLOW_LARGE);
    endfunction

endpackage

// File: rtl/dma2d_field_map.sv
module dma2d_field_map
    import dma2d_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic [3:0]    flow,
    input  logic [IW-1:0] idx,
    output desc_field_e   field
);
    localparam int PW = IW + 1;

    logic [PW-1:0] pos;
    logic [PW-1:0] skip;

    always_comb begin
        if (flow == FLOW_ARRAY)
            skip = PW'(2);
        else if ((flow == FLOW_SMALL) && (idx != '0))
            skip = PW'(1);
        else
            skip = '0;
        pos = {1'b0, idx} + skip;
        if (pos > PW'(FLD_YSTEP))
            field = FLD_NONE;
        else
            field = desc_field_e'(pos[3:0]);
    end

endmodule

// File: rtl/dma2d_stepper.sv
module dma2d_stepper #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          two_d,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] cx,
    input  logic [CW-1:0] cy,
    input  logic [CW-1:0] xlen,
    input  logic [CW-1:0] xstep,
    input  logic [CW-1:0] ystep,
    output logic [AW-1:0] next_addr,
    output logic [CW-1:0] next_cx,
    output logic [CW-1:0] next_cy,
    output logic          row_end,
    output logic          unit_end
);
    localparam int EXT = AW - CW;

    logic [AW-1:0] xs_ext;
    logic [AW-1:0] ys_ext;
    logic          last_row;

    always_comb begin
        xs_ext   = {{EXT{xstep[CW-1]}}, xstep};
        ys_ext   = {{EXT{ystep[CW-1]}}, ystep};
        row_end  = (cx == CW'(1));
        last_row = !two_d || (cy == CW'(1));
        unit_end = row_end && last_row;
        if (row_end) begin
            next_addr = addr + ys_ext;
            next_cx   = xlen;
            next_cy   = cy - CW'(1);
        end else begin
            next_addr = addr + xs_ext;
            next_cx   = cx - CW'(1);
            next_cy   = cy;
        end
    end

endmodule

// File: rtl/dma2d_walk_engine.sv
module dma2d_walk_engine
    import dma2d_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [HALF_W-1:0] cfg_in,
    input  logic [ADDR_W-1:0] start_in,
    input  logic [ADDR_W-1:0] link_in,
    input  logic [HALF_W-1:0] x_len_in,
    input  logic [HALF_W-1:0] x_step_in,
    input  logic [HALF_W-1:0] y_len_in,
    input  logic [HALF_W-1:0] y_step_in,
    input  logic              elem_take,
    input  logic              rd_gnt,
    input  logic [HALF_W-1:0] rd_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              elem_valid,
    output logic [ADDR_W-1:0] elem_addr,
    output logic              elem_write,
    output logic [1:0]        elem_width,
    output logic [HALF_W-1:0] cur_x_left,
    output logic [HALF_W-1:0] cur_y_left,
    output logic              unit_done,
    output logic              row_done,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] HALF_BYTES = ADDR_W'(HALF_W / 8);

    eng_regs_s q, d;

    // config field views of the active work unit
    logic [3:0] flow_q;
    logic [3:0] nhalf_q;
    logic [1:0] irq_sel_q;
    logic       two_d_q;

    assign flow_q    = q.cfg[15:12];
    assign nhalf_q   = q.cfg[11:8];
    assign irq_sel_q = q.cfg[7:6];
    assign two_d_q   = q.cfg[4];

    desc_field_e fld;

    dma2d_field_map #(.IW(IDX_W)) u_map (
        .flow  (q.fflow),
        .idx   (q.fidx),
        .field (fld)
    );

    logic [ADDR_W-1:0] w_addr;
    logic [HALF_W-1:0] w_cx, w_cy;
    logic              w_row_end, w_unit_end;

    dma2d_stepper #(.AW(ADDR_W), .CW(HALF_W)) u_step (
        .two_d     (two_d_q),
        .addr      (q.addr),
        .cx        (q.cx),
        .cy        (q.cy),
        .xlen      (q.xlen),
        .xstep     (q.xstep),
        .ystep     (q.ystep),
        .next_addr (w_addr),
        .next_cx   (w_cx),
        .next_cy   (w_cy),
        .row_end   (w_row_end),
        .unit_end  (w_unit_end)
    );

    always_comb begin
        d           = q;
        d.unit_done = 1'b0;
        d.row_done  = 1'b0;
        d.irq       = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (enable) begin
                    d.cfg   = cfg_in;
                    d.start = start_in;
                    d.link  = link_in;
                    d.dptr  = link_in;
                    d.xlen  = x_len_in;
                    d.xstep = x_step_in;
                    d.ylen  = y_len_in;
                    d.ystep = y_step_in;
                    d.cx    = '0;
                    d.cy    = '0;
                    if (is_fetch_flow(cfg_in[15:12]) && (cfg_in[11:8] != '0)) begin
                        d.st    = ST_FETCH;
                        d.fidx  = '0;
                        d.ftot  = cfg_in[11:8];
                        d.fflow = cfg_in[15:12];
                    end else begin
                        d.st = ST_LOAD;
                    end
                end
            end
            ST_LOAD: begin
                d.addr = q.start;
                d.cx   = q.xlen;
                d.cy   = q.ylen;
                d.st   = ST_RUN;
            end
            ST_RUN: begin
                if (elem_take) begin
                    if (!w_unit_end) begin
                        d.addr = w_addr;
                        d.cx   = w_cx;
                        d.cy   = w_cy;
                        if (w_row_end) begin
                            d.row_done = 1'b1;
                            d.irq      = (irq_sel_q == IRQ_ROW);
                        end
                    end else begin
                        d.unit_done = 1'b1;
                        d.row_done  = two_d_q;
                        d.irq       = (irq_sel_q == IRQ_UNIT) || (irq_sel_q == IRQ_ROW);
                        d.cx        = '0;
                        d.cy        = '0;
                        if (flow_q == FLOW_AUTO) begin
                            d.st = ST_LOAD;
                        end else if (is_fetch_flow(flow_q)) begin
                            if (nhalf_q == '0) begin
                                d.st = ST_LOAD;
                            end else begin
                                d.st    = ST_FETCH;
                                d.fidx  = '0;
                                d.ftot  = nhalf_q;
                                d.fflow = flow_q;
                                d.dptr  = (flow_q == FLOW_ARRAY) ? q.dptr : q.link;
                            end
                        end else begin
                            d.st = ST_HALT;
                        end
                    end
                end
            end
            ST_FETCH: begin
                if (rd_gnt) begin
                    d.dptr = q.dptr + HALF_BYTES;
                    d.fidx = q.fidx + IDX_W'(1);
                    case (fld)
                        FLD_LINK_LO:  d.link[HALF_W-1:0]        = rd_data;
                        FLD_LINK_HI:  d.link[ADDR_W-1:HALF_W]   = rd_data;
                        FLD_START_LO: d.start[HALF_W-1:0]       = rd_data;
                        FLD_START_HI: d.start[ADDR_W-1:HALF_W]  = rd_data;
                        FLD_CFG:      d.cfg                     = rd_data;
                        FLD_XLEN:     d.xlen                    = rd_data;
                        FLD_XSTEP:    d.xstep                   = rd_data;
                        FLD_YLEN:     d.ylen                    = rd_data;
                        FLD_YSTEP:    d.ystep                   = rd_data;
                        default:      ;
                    endcase
                    if (q.fidx == (q.ftot - IDX_W'(1)))
                        d.st = ST_LOAD;
                end
            end
            ST_HALT: ;
            default: d.st = ST_IDLE;
        endcase
        if (!enable)
            d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_req     = (q.st == ST_FETCH);
    assign rd_addr    = q.dptr;
    assign elem_valid = (q.st == ST_RUN);
    assign elem_addr  = q.addr;
    assign elem_write = q.cfg[1];
    assign elem_width = q.cfg[3:2];
    assign cur_x_left = q.cx;
    assign cur_y_left = q.cy;
    assign unit_done  = q.unit_done;
    assign row_done   = q.row_done;
    assign irq        = q.irq;

    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && elem_take && (cur_x_left > 16'd1))
        |=> (elem_addr == $past(elem_addr) + {{(ADDR_W-HALF_W){$past(q.xstep[HALF_W-1])}}, $past(q.xstep)}))
        else $error("row step not applied"); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        unit_done |=> !unit_done)
        else $error("unit end longer than one cycle"); // R3

    AST_ROW_ONLY_2D: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |-> two_d_q)
        else $error("row event in linear mode"); // R4

    AST_IRQ_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_sel_q[1])
        else $error("interrupt while not selected"); // R5

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && (flow_q == FLOW_STOP)) |-> !elem_valid)
        else $error("element after stop"); // R6

    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_gnt) |=> (!rd_req || (rd_addr == $past(rd_addr) + HALF_BYTES)))
        else $error("descriptor halfwords out of order"); // R8

    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!elem_valid && !rd_req))
        else $error("activity while disabled"); // R11

endmodule

// File: tb/test_dma2d_walk_engine.sv
module test_dma2d_walk_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic [15:0] cfg_in;
    logic [31:0] start_in, link_in;
    logic [15:0] x_len_in, x_step_in, y_len_in, y_step_in;
    logic        elem_take, rd_gnt;
    logic [15:0] rd_data;
    logic        rd_req, elem_valid, elem_write, unit_done, row_done, irq;
    logic [31:0] rd_addr, elem_addr;
    logic [1:0]  elem_width;
    logic [15:0] cur_x_left, cur_y_left;

    always #10 clk = ~clk;

    logic [15:0] mem [64];
    assign rd_data = mem[rd_addr[6:1]];

    dma2d_walk_engine i_dma2d_walk_engine (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_in(cfg_in),
        .start_in(start_in), .link_in(link_in), .x_len_in(x_len_in),
        .x_step_in(x_step_in), .y_len_in(y_len_in), .y_step_in(y_step_in),
        .elem_take(elem_take), .rd_gnt(rd_gnt), .rd_data(rd_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .elem_valid(elem_valid),
        .elem_addr(elem_addr), .elem_write(elem_write), .elem_width(elem_width),
        .cur_x_left(cur_x_left), .cur_y_left(cur_y_left),
        .unit_done(unit_done), .row_done(row_done), .irq(irq)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] elog [32];
    logic [31:0] flog [32];
    int egot, fgot, n_done, n_row, n_irq, n_overlap;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    endtask

    task automatic begin_unit(logic [15:0] c, logic [31:0] s, logic [31:0] l,
                              logic [15:0] xl, logic [15:0] xs,
                              logic [15:0] yl, logic [15:0] ys);
        @(negedge clk);
        cfg_in = c; start_in = s; link_in = l;
        x_len_in = xl; x_step_in = xs; y_len_in = yl; y_step_in = ys;
        enable = 1'b1;
    endtask

    task automatic end_unit();
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_elems(int n, int maxcyc, bit stall);
        egot = 0; fgot = 0; n_done = 0; n_row = 0; n_irq = 0; n_overlap = 0;
        for (int c = 0; c < maxcyc; c++) begin
            @(negedge clk);
            if (unit_done) n_done++;
            if (row_done) n_row++;
            if (irq) n_irq++;
            if (elem_valid && rd_req) n_overlap++;
            rd_gnt = stall ? c[0] : 1'b1;
            elem_take = (egot < n);
            if (rd_req && rd_gnt && fgot < 32) begin flog[fgot] = rd_addr; fgot++; end
            if (elem_valid && elem_take && egot < 32) begin elog[egot] = elem_addr; egot++; end
        end
        elem_take = 1'b0;
        rd_gnt = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; enable = 1'b0; elem_take = 1'b0; rd_gnt = 1'b0;
        cfg_in = '0; start_in = '0; link_in = '0;
        x_len_in = '0; x_step_in = '0; y_len_in = '0; y_step_in = '0;
        clear_mem();
        repeat (3) @(negedge clk);
        chk("R1", "elem_valid", elem_valid, 0);
        chk("R1", "rd_req", rd_req, 0);
        chk("R1", "events", {unit_done, row_done, irq}, 0);
        chk("R1", "counts", {cur_x_left, cur_y_left}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // linear, stop flow, unit interrupt, 32-bit write
    task automatic t_linear_stop();
        begin_unit(16'h008A, 32'h1000, 32'h0, 16'd4, 16'd4, 16'd1, 16'd0);
        @(negedge clk);
        chk("R2", "counts cleared", {cur_x_left, cur_y_left}, 0);
        chk("R2", "no element yet", elem_valid, 0);
        @(negedge clk);
        chk("R2", "first valid", elem_valid, 1);
        chk("R2", "first addr", elem_addr, 32'h1000);
        chk("R2", "x count loaded", cur_x_left, 16'd4);
        chk("R3", "width", elem_width, 2'd2);
        chk("R3", "direction", elem_write, 1'b1);
        run_elems(10, 24, 0);
        chk("R6", "elements before halt", egot, 4);
        for (int i = 0; i < 4; i++)
            chk("R3", "linear addr", elog[i], 32'h1000 + 32'(i * 4));
        chk("R3", "done pulses", n_done, 1);
        chk("R5", "unit irq", n_irq, 1);
        chk("R4", "no row events linear", n_row, 0);
        chk("R6", "halted", elem_valid, 0);
        end_unit();
    endtask

    // 2D walk with negative row-to-row step under three interrupt selections
    task automatic t_two_d();
        logic [31:0] exp_a [6];
        int          exp_irq [3];
        logic [1:0]  sel [3];
        exp_a = '{32'h2000, 32'h2002, 32'h2004, 32'h1FF4, 32'h1FF6, 32'h1FF8};
        sel = '{2'd3, 2'd2, 2'd0};
        exp_irq = '{2, 1, 0};
        for (int m = 0; m < 3; m++) begin
            begin_unit({8'h00, sel[m], 6'h14}, 32'h2000, 32'h0, 16'd3, 16'd2, 16'd2, 16'hFFF0);
            run_elems(8, 30, 0);
            chk("R4", "2D element count", egot, 6);
            for (int i = 0; i < 6; i++)
                chk("R4", "2D addr", elog[i], exp_a[i]);
            chk("R4", "row pulses", n_row, 2);
            chk("R5", "irq pulses", n_irq, exp_irq[m]);
            chk("R3", "done pulses 2D", n_done, 1);
            end_unit();
        end
    endtask

    // auto restart then abort
    task automatic t_auto_abort();
        begin_unit(16'h1080, 32'h300, 32'h0, 16'd2, 16'hFFFF, 16'd1, 16'd0);
        run_elems(6, 30, 0);
        chk("R7", "auto element count", egot, 6);
        for (int i = 0; i < 6; i++)
            chk("R7", "auto addr", elog[i], (i % 2 == 0) ? 32'h300 : 32'h2FF);
        chk("R7", "auto done pulses", n_done, 3);
        chk("R7", "still running", elem_valid, 1);
        enable = 1'b0;
        @(negedge clk);
        chk("R11", "valid drops", elem_valid, 0);
        chk("R11", "no fetch", rd_req, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_large();
        logic [15:0] da [9];
        logic [15:0] db [9];
        clear_mem();
        da = '{16'h0060, 16'h0000, 16'h5000, 16'h0000, 16'h7988, 16'd2, 16'd8, 16'd1, 16'd0};
        db = '{16'h0040, 16'h0000, 16'h6000, 16'h0000, 16'h0088, 16'd1, 16'd0, 16'd1, 16'd0};
        for (int i = 0; i < 9; i++) begin mem[32 + i] = da[i]; mem[48 + i] = db[i]; end
        begin_unit(16'h7900, 32'hDEAD0000, 32'h40, 16'd9, 16'd9, 16'd9, 16'd9);
        run_elems(8, 120, 1);
        chk("R8", "fetched halfwords", fgot, 18);
        chk("R8", "first fetch addr", flog[0], 32'h40);
        chk("R8", "last fetch addr A", flog[8], 32'h50);
        chk("R8", "link fetch addr", flog[9], 32'h60);
        chk("R8", "no element during fetch", n_overlap, 0);
        chk("R8", "element count", egot, 3);
        chk("R8", "addr 0", elog[0], 32'h5000);
        chk("R8", "addr 1", elog[1], 32'h5008);
        chk("R8", "addr 2", elog[2], 32'h6000);
        chk("R8", "done pulses", n_done, 2);
        end_unit();
    endtask

    task automatic t_small();
        logic [15:0] dc [6];
        logic [15:0] dd [6];
        clear_mem();
        dc = '{16'h0020, 16'h7000, 16'h0000, 16'h6688, 16'd1, 16'd0};
        dd = '{16'h0010, 16'h7100, 16'h0000, 16'h0088, 16'd1, 16'd0};
        for (int i = 0; i < 6; i++) begin mem[8 + i] = dc[i]; mem[16 + i] = dd[i]; end
        begin_unit(16'h6600, 32'h0, 32'h0001_0010, 16'd5, 16'd5, 16'd5, 16'd5);
        run_elems(8, 80, 0);
        chk("R9", "fetched halfwords", fgot, 12);
        chk("R9", "first fetch addr", flog[0], 32'h0001_0010);
        chk("R9", "second desc keeps high half", flog[6], 32'h0001_0020);
        chk("R9", "element count", egot, 2);
        chk("R9", "addr 0", elog[0], 32'h7000);
        chk("R9", "addr 1", elog[1], 32'h7100);
        end_unit();
    endtask

    task automatic t_array();
        logic [15:0] de [5];
        logic [15:0] df [5];
        clear_mem();
        de = '{16'h8000, 16'h0000, 16'h4588, 16'd2, 16'd4};
        df = '{16'h9000, 16'h0000, 16'h0088, 16'd1, 16'd0};
        for (int i = 0; i < 5; i++) begin mem[i] = de[i]; mem[5 + i] = df[i]; end
        begin_unit(16'h4500, 32'h0, 32'h0, 16'd7, 16'd7, 16'd7, 16'd7);
        run_elems(8, 80, 0);
        chk("R10", "fetched halfwords", fgot, 10);
        chk("R10", "second desc follows on", flog[5], 32'h0A);
        chk("R10", "last fetch addr", flog[9], 32'h12);
        chk("R10", "element count", egot, 3);
        chk("R10", "addr 0", elog[0], 32'h8000);
        chk("R10", "addr 1", elog[1], 32'h8004);
        chk("R10", "addr 2", elog[2], 32'h9000);
        end_unit();
    endtask

    initial begin
        t_reset();
        t_linear_stop();
        t_two_d();
        t_auto_abort();
        t_large();
        t_small();
        t_array();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule